// File: doc/BRIEF.md
# DSP Address Generation Unit

This block computes data-memory addresses for indirect accesses that modify the pointer after use. It holds one address register and the configuration that goes with it: a base address, a buffer length and a reversal width. A load strobe captures this configuration, chooses the update mode and sets the pointer to the base. After that, each update strobe presents the current pointer as the access address and moves the register to the post-modified value on the same clock edge. The update rule depends on the mode. Linear mode adds a signed step. Circular mode wraps the pointer inside a buffer, so the slot just written, which held the oldest sample, is followed by the next oldest. Bit-reversed mode adds the step with its carry running from the most significant bit of the field toward the least significant, for FFT reordering.

The mode is held in a small state machine with four states. After reset it is in ST_HOLD. A load moves it to ST_LINEAR (mode code 0), ST_CIRC (mode code 1), ST_BREV (mode code 2) or back to ST_HOLD (mode code 3). Any state can reach any state through a load. Without a load the state does not change. In ST_HOLD the pointer never moves.

Top module: `agu`

## Requirements
- R1: After reset `addr_o` and `next_o` are 0 and the state is ST_HOLD, so update strobes leave the pointer at 0 until a load.
- R2: A load sets the pointer to `base_i` and latches the mode, the length and the reversal width. If `load_i` and `upd_i` are high in the same cycle, the load wins.
- R3: `addr_o` always shows the unmodified pointer. `next_o` shows the value the pointer would take for the present `step_i`. On a clock edge with `upd_i` high, the pointer takes that value.
- R4: In linear mode (code 0) the next value is the pointer plus the sign-extended `step_i`, modulo 2^32.
- R5: In circular mode (code 1), with buffer length L and a step whose magnitude does not exceed L, the pointer stays in [base, base+L). A positive step that passes base+L-1 wraps to the start of the window.
- R6: In circular mode a negative step that goes below the base wraps to the top of the window, so from the base a step of -1 gives base+L-1.
- R7: The circular window length is min(`len_i`, 2^32 - base). A buffer that would run past the top of the address space is clamped to end at address 0xFFFFFFFF.
- R8: In bit-reversed mode (code 2) with width n (`nbits_i`, values above 16 treated as 16), the low n bits of the pointer are reversed and added to the reversed low n bits of the step. The sum is taken modulo 2^n and reversed back. All pointer bits at positions n and above are kept unchanged.
- R9: The degenerate settings hold the pointer: mode code 3, a circular length of 0, and a bit-reversed width of 0 each leave the pointer at its loaded value whatever the update strobes do.
- R10: When neither `load_i` nor `upd_i` is high, the pointer and the state keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the configuration and set the pointer to the base |
| mode_i | input | 2 | Update mode captured on load: 0 linear, 1 circular, 2 bit-reversed, 3 hold |
| base_i | input | 32 | Base address; the pointer's value after a load |
| len_i | input | 17 | Circular buffer length, 0 to 65536 |
| nbits_i | input | 5 | Bit-reversed field width, log2 of the FFT size |
| upd_i | input | 1 | Post-modify the pointer at this edge |
| step_i | input | 16 | Signed step for the update |
| addr_o | output | 32 | Address for the current access (pointer before modification) |
| next_o | output | 32 | Pointer value after an update with the present step |

## Verification
The cases hardest to reach from the ports are the wrap points of the circular window, and above all the clamped window at the top of the address space, where base plus length overflows 32 bits. The bench loads a small buffer for every length from 1 to 6 and runs every step from -L to +L long enough to wrap several times in both directions. It then loads a window that starts 16 addresses below the top with a length of 100 and walks it both ways. The reversed-carry field is swept through its whole period for widths 1 to 5, with the upper pointer bits set to a nonzero pattern so that any leak of a carry out of the field shows.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // mode codes as seen on mode_i
    typedef enum logic [1:0] {
        MODE_LINEAR = 2'b00,
        MODE_CIRC   = 2'b01,
        MODE_BREV   = 2'b10,
        MODE_HOLD   = 2'b11
    } agu_mode_e;

    // controller states
    typedef enum logic [1:0] {
        ST_HOLD   = 2'b00,
        ST_LINEAR = 2'b01,
        ST_CIRC   = 2'b10,
        ST_BREV   = 2'b11
    } agu_state_e;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
    import agu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] mode_i,
    output agu_state_e state_o,
    output logic       adv_o
);

    agu_state_e st_q, st_d;

    // next-state selection: only a load changes the mode
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            unique case (agu_mode_e'(mode_i))
                MODE_LINEAR: st_d = ST_LINEAR;
                MODE_CIRC:   st_d = ST_CIRC;
                MODE_BREV:   st_d = ST_BREV;
                MODE_HOLD:   st_d = ST_HOLD;
                default:     st_d = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        state_o = st_q;
        unique case (st_q)
            ST_HOLD:   adv_o = 1'b0;
            ST_LINEAR: adv_o = 1'b1;
            ST_CIRC:   adv_o = 1'b1;
            ST_BREV:   adv_o = 1'b1;
            default:   adv_o = 1'b0;
        endcase
    end

    // R10
    state_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q));

    // R2
    circ_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i == 2'b01) |=> (st_q == ST_CIRC));

    // R9
    hold_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i == 2'b11) |=> (st_q == ST_HOLD));

endmodule

// File: rtl/agu_circ_next.sv
module agu_circ_next #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 17
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [ADDR_W-1:0] step_i,   // already sign-extended
    output logic [ADDR_W-1:0] nxt_o,
    output logic [ADDR_W:0]   win_o
);

    localparam int WW = ADDR_W + 2;

    logic [ADDR_W:0]          room;
    logic [ADDR_W:0]          len_x;
    logic [ADDR_W:0]          eff;
    logic [ADDR_W-1:0]        off;
    logic signed [WW-1:0]     off_s;
    logic signed [WW-1:0]     stp_s;
    logic signed [WW-1:0]     len_s;
    logic signed [WW-1:0]     sum_s;
    logic signed [WW-1:0]     adj_s;

    always_comb begin
        // space left between base and the top of the address range
        room  = ((ADDR_W+1)'(1) << ADDR_W) - {1'b0, base_i};
        len_x = (ADDR_W+1)'(len_i);
        eff   = (len_x > room) ? room : len_x;

        off   = ptr_i - base_i;
        off_s = $signed({2'b00, off});
        stp_s = $signed({{2{step_i[ADDR_W-1]}}, step_i});
        len_s = $signed({1'b0, eff});
        sum_s = off_s + stp_s;

        if (sum_s < 0)
            adj_s = sum_s + len_s;
        else if (sum_s >= len_s)
            adj_s = sum_s - len_s;
        else
            adj_s = sum_s;

        nxt_o = (eff == '0) ? base_i : base_i + adj_s[ADDR_W-1:0];
        win_o = eff;
    end

endmodule

// File: rtl/agu_brev_next.sv
module agu_brev_next #(
    parameter int ADDR_W = 32,
    parameter int MAXB   = 16,
    parameter int SH_W   = $clog2(MAXB + 1)
) (
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic [MAXB-1:0]   step_i,
    input  logic [SH_W-1:0]   nb_i,     // field width, at most MAXB
    output logic [ADDR_W-1:0] nxt_o
);

    logic [MAXB-1:0] p_rev, s_rev, sum_rev;
    logic [MAXB-1:0] p_al, s_al, sum_f, back, mask;
    logic [MAXB:0]   one_sh, mask_w;
    logic [SH_W-1:0] sh;

    // mirror the whole MAXB-bit field; a shift then aligns to n bits
    for (genvar gi = 0; gi < MAXB; gi++) begin : g_mirror
        assign p_rev[gi]   = ptr_i[MAXB-1-gi];
        assign s_rev[gi]   = step_i[MAXB-1-gi];
        assign sum_rev[gi] = sum_f[MAXB-1-gi];
    end

    always_comb begin
        sh     = SH_W'(MAXB) - nb_i;
        one_sh = (MAXB+1)'(1) << nb_i;
        mask_w = one_sh - (MAXB+1)'(1);
        mask   = mask_w[MAXB-1:0];
        p_al   = p_rev >> sh;
        s_al   = s_rev >> sh;
        sum_f  = (p_al + s_al) & mask;
        back   = sum_rev >> sh;
    end

    if (ADDR_W > MAXB) begin : g_wide
        assign nxt_o = {ptr_i[ADDR_W-1:MAXB], (ptr_i[MAXB-1:0] & ~mask) | back};
    end else begin : g_narrow
        assign nxt_o = (ptr_i & ~mask) | back;
    end

endmodule

// File: rtl/agu.sv
module agu
    import agu_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int STEP_W   = 16,
    parameter int LEN_W    = 17,
    parameter int BREV_MAX = 16,
    localparam int NB_W    = $clog2(BREV_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [1:0]        mode_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [NB_W-1:0]   nbits_i,
    input  logic              upd_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_o
);

    agu_state_e        st;
    logic              adv;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] cfg_base;
    logic [LEN_W-1:0]  cfg_len;
    logic [NB_W-1:0]   cfg_nb;
    logic [ADDR_W-1:0] step_x;
    logic [ADDR_W-1:0] lin_nxt, circ_nxt, brev_nxt, nxt;
    logic [ADDR_W:0]   win_len;

    agu_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .mode_i  (mode_i),
        .state_o (st),
        .adv_o   (adv)
    );

    assign step_x  = {{(ADDR_W-STEP_W){step_i[STEP_W-1]}}, step_i};
    assign lin_nxt = ptr_q + step_x;

    agu_circ_next #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_circ (
        .ptr_i  (ptr_q),
        .base_i (cfg_base),
        .len_i  (cfg_len),
        .step_i (step_x),
        .nxt_o  (circ_nxt),
        .win_o  (win_len)
    );

    agu_brev_next #(.ADDR_W(ADDR_W), .MAXB(BREV_MAX), .SH_W(NB_W)) u_brev (
        .ptr_i  (ptr_q),
        .step_i (step_x[BREV_MAX-1:0]),
        .nb_i   (cfg_nb),
        .nxt_o  (brev_nxt)
    );

    always_comb begin
        unique case (st)
            ST_HOLD:   nxt = ptr_q;
            ST_LINEAR: nxt = lin_nxt;
            ST_CIRC:   nxt = circ_nxt;
            ST_BREV:   nxt = brev_nxt;
            default:   nxt = ptr_q;
        endcase
    end

    // configuration and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            cfg_base <= '0;
            cfg_len  <= '0;
            cfg_nb   <= '0;
        end else if (load_i) begin
            ptr_q    <= base_i;
            cfg_base <= base_i;
            cfg_len  <= len_i;
            cfg_nb   <= (nbits_i > NB_W'(BREV_MAX)) ? NB_W'(BREV_MAX) : nbits_i;
        end else if (upd_i && adv) begin
            ptr_q    <= nxt;
        end
    end

    assign addr_o = ptr_q;
    assign next_o = nxt;

    // field mask for the bit-reversed check
    logic [ADDR_W:0]   fld_one;
    logic [ADDR_W-1:0] fld_mask;
    assign fld_one  = (ADDR_W+1)'(1) << cfg_nb;
    assign fld_mask = fld_one[ADDR_W-1:0] - ADDR_W'(1);

    // R2
    load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (addr_o == $past(base_i)));

    // R3
    upd_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !load_i) |=> (addr_o == $past(next_o)));

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !load_i) |=> $stable(addr_o));

    // R9
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && !load_i) |=> $stable(addr_o));

    // R5
    circ_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CIRC) |->
        ({1'b0, addr_o - cfg_base} < ((win_len == '0) ? (ADDR_W+1)'(1) : win_len)));

    // R8
    brev_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BREV && upd_i && !load_i) |=>
        (((addr_o ^ $past(addr_o)) & ~fld_mask) == '0));

endmodule

// File: tb/agu_test.sv
module agu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load;
    logic [1:0]  mode;
    logic [31:0] base;
    logic [16:0] len;
    logic [4:0]  nbits;
    logic        upd;
    logic [15:0] step;
    logic [31:0] addr;
    logic [31:0] nxt;

    always #5 clk = ~clk;

    agu uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .mode_i  (mode),
        .base_i  (base),
        .len_i   (len),
        .nbits_i (nbits),
        .upd_i   (upd),
        .step_i  (step),
        .addr_o  (addr),
        .next_o  (nxt)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [31:0] mp;       // model pointer
    logic [31:0] m_base;
    logic [16:0] m_len;
    int          m_nb;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_lin(input logic [31:0] p, input logic [15:0] s);
        return p + {{16{s[15]}}, s};
    endfunction

    function automatic logic [31:0] m_circ(input logic [31:0] p, input logic [31:0] b,
                                           input logic [16:0] k, input logic [15:0] s);
        longint room, lw, off, sm;
        room = 64'h1_0000_0000 - longint'(b);
        lw   = (longint'(k) > room) ? room : longint'(k);
        if (lw == 0) return b;
        off = longint'(p) - longint'(b);
        sm  = off + longint'($signed(s));
        if (sm < 0) sm = sm + lw;
        else if (sm >= lw) sm = sm - lw;
        return 32'(longint'(b) + sm);
    endfunction

    function automatic logic [31:0] m_brev(input logic [31:0] p, input logic [15:0] s, input int n);
        logic [31:0] r, pf, sf, sm;
        r = p; pf = '0; sf = '0;
        for (int i = 0; i < n; i++) begin
            pf[n-1-i] = p[i];
            sf[n-1-i] = s[i];
        end
        sm = (pf + sf) & ((32'd1 << n) - 32'd1);
        for (int i = 0; i < n; i++) r[i] = sm[n-1-i];
        return r;
    endfunction

    task automatic do_load(input logic [1:0] m, input logic [31:0] b,
                           input logic [16:0] k, input logic [4:0] nb);
        @(negedge clk);
        load = 1'b1; mode = m; base = b; len = k; nbits = nb;
        @(posedge clk);
        #1 load = 1'b0;
        mp = b; m_base = b; m_len = k; m_nb = (nb > 16) ? 16 : int'(nb);
        chk("R2 load sets pointer", addr, b);
    endtask

    task automatic do_upd(input string tag, input logic [15:0] s, input logic [31:0] exp);
        @(negedge clk);
        step = s; upd = 1'b1;
        #1;
        chk({tag, " next"}, nxt, exp);
        chk("R3 presented address is unmodified", addr, mp);
        @(posedge clk);
        #1 upd = 1'b0;
        mp = exp;
        chk({tag, " after update"}, addr, exp);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; mode = 2'b00; base = '0; len = '0;
        nbits = '0; upd = 1'b0; step = '0; mp = '0;
        m_base = '0; m_len = '0; m_nb = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset addr", addr, 32'd0);
        chk("R1 reset next", nxt, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R1: strobes before any load do nothing
        do_upd("R1 update before load", 16'd5, 32'd0);

        // R2: load wins over a simultaneous update
        @(negedge clk);
        load = 1'b1; mode = 2'b00; base = 32'd200; len = '0; nbits = '0;
        upd = 1'b1; step = 16'd7;
        @(posedge clk);
        #1 load = 1'b0; upd = 1'b0;
        mp = 32'd200;
        chk("R2 load beats update", addr, 32'd200);

        // R10: idle cycles leave the pointer alone
        repeat (3) @(posedge clk);
        #1 chk("R10 idle pointer", addr, 32'd200);

        // R4: linear mode
        do_upd("R4 linear +7", 16'd7, 32'd207);
        do_upd("R4 linear min step", 16'h8000, m_lin(32'd207, 16'h8000));
        do_upd("R4 linear max step", 16'h7FFF, m_lin(m_lin(32'd207, 16'h8000), 16'h7FFF));
        do_load(2'b00, 32'hFFFF_FFFE, '0, '0);
        do_upd("R4 linear wrap up", 16'd5, 32'd3);
        do_upd("R4 linear wrap down", 16'hFFF8, 32'hFFFF_FFFB);

        // R5/R6: circular sweep over lengths and all legal steps
        for (int k = 1; k <= 6; k++) begin
            for (int s = -k; s <= k; s++) begin
                do_load(2'b01, 32'd1000, 17'(k), '0);
                for (int u = 0; u < 2*k + 1; u++) begin
                    if (s >= 0)
                        do_upd("R5 circular forward", 16'(s), m_circ(mp, m_base, m_len, 16'(s)));
                    else
                        do_upd("R6 circular backward", 16'(s), m_circ(mp, m_base, m_len, 16'(s)));
                end
            end
        end
        do_load(2'b01, 32'd4000, 17'd10, '0);
        do_upd("R6 base minus one", 16'hFFFF, 32'd4009);

        // R7: window clamped at the top of the address range
        do_load(2'b01, 32'hFFFF_FFF0, 17'd100, '0);
        for (int u = 0; u < 20; u++)
            do_upd("R7 clamped forward", 16'd5, m_circ(mp, m_base, m_len, 16'd5));
        for (int u = 0; u < 20; u++)
            do_upd("R7 clamped backward", 16'hFFFD, m_circ(mp, m_base, m_len, 16'hFFFD));

        // R8: bit-reversed sweeps, upper bits nonzero
        for (int n = 1; n <= 5; n++) begin
            do_load(2'b10, 32'hABCD_5A00, '0, 5'(n));
            for (int u = 0; u < (1 << n) + 1; u++)
                do_upd("R8 reversed step 1", 16'd1, m_brev(mp, 16'd1, m_nb));
            do_load(2'b10, 32'hABCD_5A00, '0, 5'(n));
            for (int u = 0; u < (1 << n) + 1; u++)
                do_upd("R8 reversed step 3", 16'd3, m_brev(mp, 16'd3, m_nb));
            do_load(2'b10, 32'hABCD_5A00, '0, 5'(n));
            for (int u = 0; u < 4; u++)
                do_upd("R8 reversed step -1", 16'hFFFF, m_brev(mp, 16'hFFFF, m_nb));
        end
        do_load(2'b10, 32'h1234_5678, '0, 5'd20);
        do_upd("R8 width clamp to 16", 16'd1, m_brev(32'h1234_5678, 16'd1, 16));

        // R9: degenerate settings hold the pointer
        do_load(2'b11, 32'd55, 17'd9, 5'd3);
        do_upd("R9 hold mode", 16'd3, 32'd55);
        do_load(2'b10, 32'd77, '0, 5'd0);
        do_upd("R9 zero reversal width", 16'd1, 32'd77);
        do_load(2'b01, 32'd88, 17'd0, '0);
        do_upd("R9 zero circular length", 16'd1, 32'd88);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule